// File: doc/BRIEF.md
# SPI Wiper Command Front End

This block is the serial slave that sits in front of a small bank of 9-bit potentiometer wiper registers. A host lowers chip select and clocks in command bytes MSB first. Each command byte holds a 4-bit register address, a 2-bit opcode and two data bits. Write and read commands take a second byte. Increment and decrement commands are one byte long, so several of them can be chained inside one chip-select window. A wiper code of 0x100 is full scale, and the register bank never holds a larger value.

The serial pins are oversampled by the system clock through synchronisers. SDI is captured on rising SCK edges and SDO is updated on falling SCK edges. While the address and opcode bits are arriving, the block checks the pair and reports the result in the SDO slot that lines up with the unused D9 bit. An invalid pair locks the interface until chip select goes high again. A command takes effect only once its last clock has arrived, so traffic cut short by chip select changes nothing.

Top module: `spi_pot_if`

## Requirements
- R1: After a synchronous reset, every wiper holds 0x080 and SDO is 0.
- R2: Command bits arrive MSB first, in the order address[3:0], opcode[1:0], D9, D8. Opcode 00 (write) takes a second byte, and {D8, byte} is written to the addressed wiper once the 16th clock has arrived.
- R3: A written value above 0x100 is stored as 0x100.
- R4: Opcode 01 (increment) is one byte long and adds 1 to the addressed wiper, saturating at 0x100.
- R5: Opcode 10 (decrement) is one byte long and subtracts 1 from the addressed wiper, saturating at 0x000.
- R6: For opcode 11 (read), SDO carries wiper bit 8 in the D8 slot (the 8th bit of the command byte). During the second byte it carries wiper bits 7..0, MSB first.
- R7: For a valid command, SDO is 1 in the six address and opcode slots and in the write data byte. In the D9 slot (the 7th bit), SDO is 1 when the address is 0 or 1 and 0 for any other address.
- R8: After an invalid address, the rest of the chip-select window is ignored and SDO stays 0. The next window works normally.
- R9: A command cut short by chip select going high has no effect.
- R10: SCK and SDI activity while chip select is high has no effect, and SDO stays 0.
- R11: Several commands sent back to back in one chip-select window are each executed in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial data to the host (status flag and read data) |
| wiper_flat | output | NUM_WIPERS*WIPER_W | Wiper codes, wiper i in bits [i*WIPER_W +: WIPER_W] |

## Verification
A table of single-command windows is run through each opcode. It uses both addresses, both saturation limits, a write with D8 set and a write value above full scale, so the table separates correct bit order, clamping and saturation from an off-by-one or a wrong wiper. The SDO byte returned for each command is compared as well, which catches a misplaced status slot or read data shifted by one bit. Directed windows then chain three commands under one chip select and put a valid write behind an invalid address. They also cut commands short at 7 and 12 clocks and toggle SCK with chip select high. These cases tell proper framing and lockout apart from designs that execute early or keep state across windows.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_INC   = 2'b01,
    OP_DEC   = 2'b10,
    OP_READ  = 2'b11
  } pot_op_e;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } pot_phase_e;
endpackage

// File: rtl/spi_pot_sync.sv
module spi_pot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_in,
  input  logic sck_in,
  input  logic sdi_in,
  output logic cs_active,
  output logic cs_start,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi_s
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] cs_q, sck_q, sdi_q;
  logic         cs_d, sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= '1;
      sck_q <= '0;
      sdi_q <= '0;
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_q  <= {cs_q[TOP-1:0], cs_n_in};
      sck_q <= {sck_q[TOP-1:0], sck_in};
      sdi_q <= {sdi_q[TOP-1:0], sdi_in};
      cs_d  <= cs_q[TOP];
      sck_d <= sck_q[TOP];
    end
  end

  assign cs_active = !cs_q[TOP];
  assign cs_start  = cs_d && !cs_q[TOP];
  assign sck_rise  = !sck_d && sck_q[TOP];
  assign sck_fall  = sck_d && !sck_q[TOP];
  assign sdi_s     = sdi_q[TOP];
endmodule

// File: rtl/spi_pot_shift.sv
module spi_pot_shift
  import spi_pot_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int WIPER_W    = 9,
  parameter int NUM_WIPERS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_active,
  input  logic               cs_start,
  input  logic               sck_rise,
  input  logic               sck_fall,
  input  logic               sdi,
  input  logic [WIPER_W-1:0] rd_word,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic               we,
  output logic               inc,
  output logic               dec,
  output logic [WIPER_W-1:0] wdata,
  output logic               sdo
);
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = $clog2(BYTE_W);
  localparam int OPC_END = ADDR_W + 1;
  localparam logic [CNT_W-1:0] SLOT_FLAG = CNT_W'(ADDR_W + 2);
  localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] SLOT_OPC  = CNT_W'(OPC_END);
  localparam logic [ADDR_W-1:0] ADDR_LIM = ADDR_W'(NUM_WIPERS);

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-2:0] sr;
  logic [BYTE_W-1:0] sr_n;
  pot_phase_e        phase;
  pot_op_e           op;
  logic              d8;
  logic              locked;
  logic              sdo_next;

  assign sr_n = {sr, sdi};

  always_comb begin
    sdo_next = 1'b1;
    if (phase == PH_CMD) begin
      if (cnt == SLOT_FLAG)      sdo_next = 1'b1;
      else if (cnt == SLOT_LAST) sdo_next = rd_word[WIPER_W-1];
    end else if (op == OP_READ) begin
      sdo_next = rd_word[SLOT_LAST - cnt];
    end
  end

  always_ff @(posedge clk) begin
    we  <= 1'b0;
    inc <= 1'b0;
    dec <= 1'b0;
    if (rst || !cs_active || cs_start) begin
      cnt    <= '0;
      sr     <= '0;
      phase  <= PH_CMD;
      locked <= 1'b0;
      sdo    <= cs_start && !rst;
      if (rst) begin
        cmd_addr <= '0;
        op       <= OP_WRITE;
        d8       <= 1'b0;
        wdata    <= '0;
      end
    end else if (locked) begin
      sdo <= 1'b0;
    end else if (sck_rise) begin
      sr  <= sr_n[BYTE_W-2:0];
      cnt <= cnt + 1'b1;
      if (phase == PH_CMD) begin
        if (cnt == SLOT_OPC) begin
          cmd_addr <= sr_n[OPC_END:2];
          op       <= pot_op_e'(sr_n[1:0]);
          if (sr_n[OPC_END:2] >= ADDR_LIM) locked <= 1'b1;
        end
        if (cnt == SLOT_LAST) begin
          d8 <= sdi;
          case (op)
            OP_INC:  inc   <= 1'b1;
            OP_DEC:  dec   <= 1'b1;
            default: phase <= PH_DATA;
          endcase
        end
      end else if (cnt == SLOT_LAST) begin
        phase <= PH_CMD;
        if (op == OP_WRITE) begin
          we    <= 1'b1;
          wdata <= {d8, sr_n};
        end
      end
    end else if (sck_fall) begin
      sdo <= sdo_next;
    end
  end

  // R8: once locked, SDO is driven low from the next cycle on
  p_lock_sdo_low_r8: assert property (@(posedge clk) disable iff (rst)
    (locked && cs_active && !cs_start) |=> !sdo);
  // R11: at most one register operation is issued per cycle
  p_one_op_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({we, inc, dec}));
  // R10: with chip select inactive, no operation is issued and SDO stays low
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!cs_active && $past(!cs_active)) |-> (!we && !inc && !dec && !sdo));
endmodule

// File: rtl/spi_pot_regs.sv
module spi_pot_regs #(
  parameter int ADDR_W     = 4,
  parameter int WIPER_W    = 9,
  parameter int NUM_WIPERS = 2,
  parameter logic [WIPER_W-1:0] RESET_VAL = 9'h080
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          we,
  input  logic                          inc,
  input  logic                          dec,
  input  logic [WIPER_W-1:0]            wdata,
  output logic [WIPER_W-1:0]            rd_word,
  output logic [NUM_WIPERS*WIPER_W-1:0] wiper_flat
);
  localparam logic [WIPER_W-1:0] FULL = WIPER_W'(1) << (WIPER_W - 1);

  logic [WIPER_W-1:0] mem [NUM_WIPERS];

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_WIPERS; i++)
      if (addr == ADDR_W'(i)) rd_word = mem[i];
  end

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_wiper
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);

    always_ff @(posedge clk) begin
      if (rst) begin
        mem[g] <= RESET_VAL;
      end else if (addr == MY_ADDR) begin
        if (we)                          mem[g] <= (wdata > FULL) ? FULL : wdata;
        else if (inc && mem[g] != FULL)  mem[g] <= mem[g] + 1'b1;
        else if (dec && mem[g] != '0)    mem[g] <= mem[g] - 1'b1;
      end
    end

    assign wiper_flat[g*WIPER_W +: WIPER_W] = mem[g];

    // R3: a stored wiper code never exceeds full scale
    p_in_range_r3: assert property (@(posedge clk) disable iff (rst)
      mem[g] <= FULL);
    // R4: increment at full scale leaves the code at full scale
    p_inc_sat_r4: assert property (@(posedge clk) disable iff (rst)
      (inc && addr == MY_ADDR && mem[g] == FULL) |=> mem[g] == FULL);
    // R5: decrement at zero leaves the code at zero
    p_dec_sat_r5: assert property (@(posedge clk) disable iff (rst)
      (dec && addr == MY_ADDR && mem[g] == '0) |=> mem[g] == '0);
    // R9: without a completed command the wiper does not move
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !(we || inc || dec) |=> $stable(mem[g]));
  end
endmodule

// File: rtl/spi_pot_if.sv
module spi_pot_if #(
  parameter int ADDR_W      = 4,
  parameter int WIPER_W     = 9,
  parameter int NUM_WIPERS  = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [WIPER_W-1:0] RESET_VAL = 9'h080
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          spi_cs_n,
  input  logic                          spi_sck,
  input  logic                          spi_sdi,
  output logic                          spi_sdo,
  output logic [NUM_WIPERS*WIPER_W-1:0] wiper_flat
);
  logic               cs_active, cs_start, sck_rise, sck_fall, sdi_s;
  logic [ADDR_W-1:0]  cmd_addr;
  logic               we, inc, dec;
  logic [WIPER_W-1:0] wdata, rd_word;

  spi_pot_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .cs_n_in(spi_cs_n), .sck_in(spi_sck), .sdi_in(spi_sdi),
    .cs_active(cs_active), .cs_start(cs_start),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_s(sdi_s)
  );

  spi_pot_shift #(.ADDR_W(ADDR_W), .WIPER_W(WIPER_W), .NUM_WIPERS(NUM_WIPERS)) u_shift (
    .clk(clk), .rst(rst),
    .cs_active(cs_active), .cs_start(cs_start),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi(sdi_s),
    .rd_word(rd_word), .cmd_addr(cmd_addr),
    .we(we), .inc(inc), .dec(dec), .wdata(wdata), .sdo(spi_sdo)
  );

  spi_pot_regs #(.ADDR_W(ADDR_W), .WIPER_W(WIPER_W), .NUM_WIPERS(NUM_WIPERS),
                 .RESET_VAL(RESET_VAL)) u_regs (
    .clk(clk), .rst(rst), .addr(cmd_addr),
    .we(we), .inc(inc), .dec(dec), .wdata(wdata),
    .rd_word(rd_word), .wiper_flat(wiper_flat)
  );
endmodule

// File: tb/spi_pot_if_tb.sv
module spi_pot_if_tb;
  localparam int HALF = 8;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] data;
    logic       two;
    logic [7:0] rx_c;
    logic [7:0] rx_d;
    logic [8:0] w0;
    logic [8:0] w1;
  } vec_t;

  // Rows cover R2 R3 R4 R5 R6 R7 R8; wipers start at 0x080
  localparam vec_t VECS [11] = '{
    '{8'h00, 8'hA5, 1'b1, 8'hFE, 8'hFF, 9'h0A5, 9'h080}, // R2 write w0
    '{8'h11, 8'hC3, 1'b1, 8'hFE, 8'hFF, 9'h0A5, 9'h100}, // R3 clamp w1
    '{8'h14, 8'h00, 1'b0, 8'hFF, 8'h00, 9'h0A5, 9'h100}, // R4 inc sat
    '{8'h1C, 8'h00, 1'b1, 8'hFF, 8'h00, 9'h0A5, 9'h100}, // R6 read w1
    '{8'h08, 8'h00, 1'b0, 8'hFE, 8'h00, 9'h0A4, 9'h100}, // R5 dec
    '{8'h0C, 8'h00, 1'b1, 8'hFE, 8'hA4, 9'h0A4, 9'h100}, // R6 read w0
    '{8'h00, 8'h00, 1'b1, 8'hFE, 8'hFF, 9'h000, 9'h100}, // R2 write zero
    '{8'h08, 8'h00, 1'b0, 8'hFE, 8'h00, 9'h000, 9'h100}, // R5 dec sat
    '{8'h50, 8'h33, 1'b1, 8'hFC, 8'h00, 9'h000, 9'h100}, // R7 R8 bad addr
    '{8'h10, 8'hFF, 1'b1, 8'hFF, 8'hFF, 9'h000, 9'h0FF}, // R2 write w1
    '{8'h14, 8'h00, 1'b0, 8'hFE, 8'h00, 9'h000, 9'h100}  // R4 inc
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic        sdo;
  logic [17:0] wiper_flat;
  logic [8:0]  w0, w1;
  int          checks = 0, fails = 0;

  assign w0 = wiper_flat[8:0];
  assign w1 = wiper_flat[17:9];

  always #2.5 clk = ~clk;

  spi_pot_if u_dut (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck),
    .spi_sdi(sdi), .spi_sdo(sdo), .wiper_flat(wiper_flat)
  );

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic cs_open();
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_close();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [15:0] tx, input int n, output logic [15:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) sdi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = sdo;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired, run hung");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] rx;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 wiper0 reset", 16'(w0), 16'h080);
    chk("R1 wiper1 reset", 16'(w1), 16'h080);
    chk("R1 sdo reset", 16'(sdo), 16'h0);

    for (int v = 0; v < 11; v++) begin
      cs_open();
      xfer_bits(16'(VECS[v].cmd), 8, rx);
      chk($sformatf("vector %0d cmd sdo (R6 R7 R8)", v), rx, 16'(VECS[v].rx_c));
      if (VECS[v].two) begin
        xfer_bits(16'(VECS[v].data), 8, rx);
        chk($sformatf("vector %0d data sdo (R6 R8)", v), rx, 16'(VECS[v].rx_d));
      end
      cs_close();
      chk($sformatf("vector %0d wiper0 (R2 R3 R5)", v), 16'(w0), 16'(VECS[v].w0));
      chk($sformatf("vector %0d wiper1 (R2 R3 R4)", v), 16'(w1), 16'(VECS[v].w1));
    end

    // R11: inc w0, inc w0, write w1 = 0x012 in one window
    cs_open();
    xfer_bits(16'h0004, 8, rx);
    xfer_bits(16'h0004, 8, rx);
    xfer_bits(16'h1012, 16, rx);
    cs_close();
    chk("R11 chained wiper0", 16'(w0), 16'h002);
    chk("R11 chained wiper1", 16'(w1), 16'h012);

    // R8: invalid address then valid write in same window is ignored
    cs_open();
    xfer_bits(16'h0024, 8, rx);
    chk("R8 bad cmd sdo", rx, 16'h00FC);
    xfer_bits(16'h0077, 16, rx);
    chk("R8 locked sdo low", rx, 16'h0000);
    chk("R8 sdo held low", 16'(sdo), 16'h0);
    cs_close();
    chk("R8 write ignored", 16'(w0), 16'h002);
    cs_open();
    xfer_bits(16'h0077, 16, rx);
    cs_close();
    chk("R8 next window works", 16'(w0), 16'h077);

    // R9: partial write (12 clocks) and partial increment (7 clocks)
    cs_open();
    xfer_bits(16'h0101, 12, rx);
    cs_close();
    chk("R9 partial write", 16'(w0), 16'h077);
    cs_open();
    xfer_bits(16'h0002, 7, rx);
    cs_close();
    chk("R9 partial inc", 16'(w0), 16'h077);

    // R10: clocks with chip select high
    for (int k = 0; k < 16; k++) begin
      @(negedge clk) sdi = k[0];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      chk("R10 sdo idle low", 16'(sdo), 16'h0);
      sck = 1'b0;
    end
    repeat (2 * HALF) @(negedge clk);
    chk("R10 wiper0 unchanged", 16'(w0), 16'h077);
    chk("R10 wiper1 unchanged", 16'(w1), 16'h012);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule